// File: doc/BRIEF.md
# MMU Access Fault Checker

This block judges a single memory access whose descriptor has already been fetched and resolved. Each access comes with its virtual address, its size, its direction (read or write), its privilege level, and whether it is an instruction fetch or a data access. The resolved descriptor says whether a mapping exists, which of four mapping kinds it is (1 MB section, 64 KB large page, 4 KB small page, 1 KB tiny page), which of the sixteen domains owns it, and a vector of four 2-bit permission fields. A 32-bit domain control word supplies the access rights for each domain.

In priority order, the checker tests alignment, then translation, then domain rights, then page permission. Alignment is always checked. The other three checks apply only while the translation enable is high. For large and small pages the permission field is picked by address bits; for sections and tiny pages a single field covers the whole mapping. A fault raises a one-cycle abort to the core together with a 4-bit fault code. Data-side faults also load a fault status word and a fault address word. Instruction-side faults leave both untouched.

Top module: `mmu_fault_checker`

## Requirements
- R1: An access is misaligned when its size is halfword (`accSize`=01) and `accAddr[0]`=1, or its size is word (`accSize`=10 or 11) and `accAddr[1:0]`!=0. Byte accesses (00) are never misaligned. A misaligned access faults with code 0001 whatever the translation enable or the descriptor says, and this fault wins over every other fault.
- R2: While `mmuEnable`=0, an aligned access never aborts.
- R3: With `mmuEnable`=1 and `mapValid`=0, an aligned access takes a translation fault. The code is 0101 when `mapKind`=00 (section) and 0111 for the page kinds (01 large, 10 small, 11 tiny).
- R4: Domain d takes its rights from `domainCtl[2d+1:2d]`. The value 00 (no access) and the value 10 (reserved) both give a domain fault. The code is 1001 for a section and 1011 for a page.
- R5: Domain rights 11 (manager) let any access with a valid mapping through, whatever the permission fields hold.
- R6: Under domain rights 01 (client), the selected 2-bit permission field decides. 00 denies every access. 01 allows privileged accesses only. 10 allows privileged reads and writes and user reads. 11 allows everything. A denied access faults with code 1101 for a section and 1111 for a page. `accUser`=1 marks a user access and `accWrite`=1 marks a write.
- R7: Permission field i sits at `mapPerm[2i+1:2i]`. A large page selects i from `accAddr[15:14]` and a small page selects i from `accAddr[11:10]`. Sections and tiny pages always use field 0.
- R8: After reset, `abortValid`, `abortCode`, `faultStatus` and `faultAddr` are zero. An access presented with `accValid`=1 at a rising edge shows its result on `abortValid` and `abortCode` from that edge until the next one. `abortValid` is high only for a faulting access, and `abortCode` is 0000 when there is no abort.
- R9: A data-side fault (`accIsFetch`=0) loads `faultStatus` = {domain, code} and `faultAddr` = `accAddr` at the same edge that raises `abortValid`. The domain field is `mapDomain` for domain and permission faults and 0000 for alignment and translation faults.
- R10: Instruction-fetch faults and accesses that do not fault leave `faultStatus` and `faultAddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Virtual address of the access |
| accSize | input | 2 | 00 byte, 01 halfword, 10/11 word |
| accWrite | input | 1 | 1 for a write |
| accUser | input | 1 | 1 for a user-mode access |
| accIsFetch | input | 1 | 1 for an instruction fetch |
| mmuEnable | input | 1 | Translation and protection checks enabled |
| mapValid | input | 1 | Descriptor holds a valid mapping |
| mapKind | input | 2 | 00 section, 01 large, 10 small, 11 tiny |
| mapDomain | input | 4 | Domain number of the mapping |
| mapPerm | input | 8 | Four 2-bit permission fields |
| domainCtl | input | 32 | Sixteen 2-bit domain rights fields |
| abortValid | output | 1 | Abort to the core |
| abortCode | output | 4 | Fault code of the abort |
| faultStatus | output | 8 | Last data fault: {domain, code} |
| faultAddr | output | 32 | Address of the last data fault |

## Verification
Every result of this block arrives exactly one rising edge after the access is presented. `abortValid` and `abortCode` come from that edge, and for a data fault the status and address words are loaded at the same edge. The bench drives each access at a falling edge and lets one rising edge pass. It reads all four outputs at the next falling edge and then removes `accValid`. Before each access it takes a copy of the status and address words, so that the instruction-fetch and no-fault cases can be checked for words that did not change.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

  typedef enum logic [1:0] {
    MAP_SECTION = 2'b00,
    MAP_LARGE   = 2'b01,
    MAP_SMALL   = 2'b10,
    MAP_TINY    = 2'b11
  } mapKind_e;

  localparam logic [3:0] FC_NONE       = 4'b0000;
  localparam logic [3:0] FC_ALIGN      = 4'b0001;
  localparam logic [3:0] FC_TRANS_SEC  = 4'b0101;
  localparam logic [3:0] FC_TRANS_PAGE = 4'b0111;
  localparam logic [3:0] FC_DOM_SEC    = 4'b1001;
  localparam logic [3:0] FC_DOM_PAGE   = 4'b1011;
  localparam logic [3:0] FC_PERM_SEC   = 4'b1101;
  localparam logic [3:0] FC_PERM_PAGE  = 4'b1111;

  typedef struct packed {
    logic       fire;       // faulting access this cycle
    logic       loadRecord; // data-side fault: load status/address
    logic       useDomain;  // record the mapping's domain number
    logic [3:0] code;       // fault code
  } ctrlStrobe_t;

endpackage

// File: rtl/mmu_fault_dp.sv
module mmu_fault_dp
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_DOM = 16,
  parameter int SUB_N   = 4,
  parameter int LARGE_SEL_LSB = 14,
  parameter int SMALL_SEL_LSB = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               size,
  input  logic [1:0]               kind,
  input  logic [2*SUB_N-1:0]       permVec,
  input  logic [$clog2(NUM_DOM)-1:0] domain,
  input  logic [2*NUM_DOM-1:0]     domainCtl,
  input  ctrlStrobe_t              strobe,
  output logic                     misaligned,
  output logic [1:0]               selPerm,
  output logic [1:0]               domField,
  output logic [4+$clog2(NUM_DOM)-1:0] faultStatus,
  output logic [ADDR_W-1:0]        faultAddr
);
  localparam int DOM_W = $clog2(NUM_DOM);
  localparam int SEL_W = $clog2(SUB_N);

  logic [1:0] subPerm [SUB_N];
  logic [1:0] domCode [NUM_DOM];
  logic [SEL_W-1:0] subIdx;

  for (genvar g = 0; g < SUB_N; g++) begin : g_sub
    assign subPerm[g] = permVec[2*g +: 2];
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign domCode[d] = domainCtl[2*d +: 2];
  end

  // Subpage index depends on mapping size.
  always_comb begin
    case (kind)
      MAP_LARGE: subIdx = addr[LARGE_SEL_LSB +: SEL_W];
      MAP_SMALL: subIdx = addr[SMALL_SEL_LSB +: SEL_W];
      default:   subIdx = '0;
    endcase
  end

  assign selPerm  = subPerm[subIdx];
  assign domField = domCode[domain];

  always_comb begin
    case (size)
      2'b00:   misaligned = 1'b0;
      2'b01:   misaligned = addr[0];
      default: misaligned = |addr[1:0];
    endcase
  end

  // Fault record registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
    end else if (strobe.fire && strobe.loadRecord) begin
      faultStatus <= {(strobe.useDomain ? domain : {DOM_W{1'b0}}), strobe.code};
      faultAddr   <= addr;
    end
  end

endmodule

// File: rtl/mmu_fault_ctrl.sv
module mmu_fault_ctrl
  import mmu_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accIsFetch,
  input  logic        accUser,
  input  logic        accWrite,
  input  logic        mmuEnable,
  input  logic        mapValid,
  input  logic [1:0]  kind,
  input  logic        misaligned,
  input  logic [1:0]  selPerm,
  input  logic [1:0]  domField,
  output ctrlStrobe_t strobe,
  output logic        abortValid,
  output logic [3:0]  abortCode
);
  logic       isPage;
  logic       permOk;
  logic [3:0] code;
  logic       useDom;

  assign isPage = (mapKind_e'(kind) != MAP_SECTION);

  always_comb begin
    case (selPerm)
      2'b00:   permOk = 1'b0;
      2'b01:   permOk = !accUser;
      2'b10:   permOk = !accUser || !accWrite;
      default: permOk = 1'b1;
    endcase
  end

  // Fixed priority: alignment, translation, domain, permission.
  always_comb begin
    code   = FC_NONE;
    useDom = 1'b0;
    if (misaligned) begin
      code = FC_ALIGN;
    end else if (mmuEnable) begin
      if (!mapValid) begin
        code = isPage ? FC_TRANS_PAGE : FC_TRANS_SEC;
      end else if (domField == 2'b00 || domField == 2'b10) begin
        code   = isPage ? FC_DOM_PAGE : FC_DOM_SEC;
        useDom = 1'b1;
      end else if (domField == 2'b01 && !permOk) begin
        code   = isPage ? FC_PERM_PAGE : FC_PERM_SEC;
        useDom = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.fire       = accValid && (code != FC_NONE);
    strobe.loadRecord = accValid && (code != FC_NONE) && !accIsFetch;
    strobe.useDomain  = useDom;
    strobe.code       = code;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortValid <= 1'b0;
      abortCode  <= FC_NONE;
    end else begin
      abortValid <= strobe.fire;
      abortCode  <= strobe.fire ? code : FC_NONE;
    end
  end

  p_align_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    accValid && misaligned |=> abortValid && abortCode == FC_ALIGN);

  p_off_no_xlate_r2: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !mmuEnable && !misaligned |=> !abortValid);

  p_manager_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    accValid && mmuEnable && mapValid && !misaligned && domField == 2'b11 |=> !abortValid);

  p_abort_needs_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> $past(accValid));

  p_code_zero_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !abortValid |-> abortCode == FC_NONE);

endmodule

// File: rtl/mmu_fault_checker.sv
module mmu_fault_checker
  import mmu_fault_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_DOM = 16,
  parameter int SUB_N   = 4,
  localparam int DOM_W  = $clog2(NUM_DOM)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [1:0]           accSize,
  input  logic                 accWrite,
  input  logic                 accUser,
  input  logic                 accIsFetch,
  input  logic                 mmuEnable,
  input  logic                 mapValid,
  input  logic [1:0]           mapKind,
  input  logic [DOM_W-1:0]     mapDomain,
  input  logic [2*SUB_N-1:0]   mapPerm,
  input  logic [2*NUM_DOM-1:0] domainCtl,
  output logic                 abortValid,
  output logic [3:0]           abortCode,
  output logic [4+DOM_W-1:0]   faultStatus,
  output logic [ADDR_W-1:0]    faultAddr
);
  ctrlStrobe_t strobe;
  logic        misaligned;
  logic [1:0]  selPerm;
  logic [1:0]  domField;

  mmu_fault_dp #(
    .ADDR_W(ADDR_W), .NUM_DOM(NUM_DOM), .SUB_N(SUB_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(accAddr), .size(accSize), .kind(mapKind),
    .permVec(mapPerm), .domain(mapDomain), .domainCtl(domainCtl), .strobe(strobe),
    .misaligned(misaligned), .selPerm(selPerm), .domField(domField),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  mmu_fault_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsFetch(accIsFetch),
    .accUser(accUser), .accWrite(accWrite), .mmuEnable(mmuEnable),
    .mapValid(mapValid), .kind(mapKind), .misaligned(misaligned),
    .selPerm(selPerm), .domField(domField), .strobe(strobe),
    .abortValid(abortValid), .abortCode(abortCode)
  );

  p_data_far_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortValid && !$past(accIsFetch) |-> faultAddr == $past(accAddr));

  p_fetch_keeps_record_r10: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accIsFetch |=> $stable(faultAddr) && $stable(faultStatus));

endmodule

// File: tb/mmu_fault_checker_tb.sv
`timescale 1ns/1ps
module mmu_fault_checker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        accWrite = 1'b0, accUser = 1'b0, accIsFetch = 1'b0;
  logic        mmuEnable = 1'b0, mapValid = 1'b0;
  logic [1:0]  mapKind = '0;
  logic [3:0]  mapDomain = '0;
  logic [7:0]  mapPerm = '0;
  logic [31:0] domainCtl = '0;
  logic        abortValid;
  logic [3:0]  abortCode;
  logic [7:0]  faultStatus;
  logic [31:0] faultAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mmu_fault_checker u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSize(accSize), .accWrite(accWrite), .accUser(accUser),
    .accIsFetch(accIsFetch), .mmuEnable(mmuEnable), .mapValid(mapValid),
    .mapKind(mapKind), .mapDomain(mapDomain), .mapPerm(mapPerm),
    .domainCtl(domainCtl), .abortValid(abortValid), .abortCode(abortCode),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Presents the current inputs for one cycle and checks every result.
  task automatic issue(input logic [3:0] expCode, input string req);
    logic [7:0]  prevStatus = faultStatus;
    logic [31:0] prevAddr   = faultAddr;
    logic [7:0]  expStatus;
    accValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0;
    check(abortValid == (expCode != 4'b0000), {req, " abortValid"}, 32'(abortValid), 32'(expCode != 0));
    check(abortCode == expCode, {req, " abortCode"}, 32'(abortCode), 32'(expCode));
    if (expCode != 4'b0000 && !accIsFetch) begin
      expStatus = {(expCode[3] ? mapDomain : 4'h0), expCode};
      check(faultStatus == expStatus, {req, " R9 faultStatus"}, 32'(faultStatus), 32'(expStatus));
      check(faultAddr == accAddr, {req, " R9 faultAddr"}, faultAddr, accAddr);
    end else begin
      check(faultStatus == prevStatus, {req, " R10 faultStatus kept"}, 32'(faultStatus), 32'(prevStatus));
      check(faultAddr == prevAddr, {req, " R10 faultAddr kept"}, faultAddr, prevAddr);
    end
  endtask

  task automatic setMap(input logic v, input logic [1:0] k, input logic [3:0] d, input logic [7:0] p);
    mapValid = v; mapKind = k; mapDomain = d; mapPerm = p;
  endtask

  task automatic t_reset;
    check(abortValid == 1'b0, "R8 reset abortValid", 32'(abortValid), 0);
    check(abortCode == 4'b0, "R8 reset abortCode", 32'(abortCode), 0);
    check(faultStatus == 8'b0, "R8 reset faultStatus", 32'(faultStatus), 0);
    check(faultAddr == 32'b0, "R8 reset faultAddr", faultAddr, 0);
  endtask

  task automatic t_alignment;
    mmuEnable = 1'b0; setMap(1'b0, 2'b00, 4'h3, 8'h00);
    accIsFetch = 0; accWrite = 0; accUser = 0;
    accSize = 2'b01; accAddr = 32'h0000_1001; issue(4'b0001, "R1 odd halfword, MMU off");
    accSize = 2'b00; accAddr = 32'h0000_1003; issue(4'b0000, "R1 byte any address");
    accSize = 2'b10; accAddr = 32'h0000_2002; issue(4'b0000 | 4'b0001, "R1 word bit1 set");
    mmuEnable = 1'b1;
    accSize = 2'b11; accAddr = 32'h0000_3001; issue(4'b0001, "R1 alignment beats translation");
    accSize = 2'b01; accAddr = 32'h0000_3002; domainCtl = '0; setMap(1'b1, 2'b00, 4'h3, 8'h00);
    mapValid = 1'b0; issue(4'b0101, "R3 aligned halfword reaches translation");
  endtask

  task automatic t_mmu_off;
    mmuEnable = 1'b0; setMap(1'b0, 2'b10, 4'h0, 8'h00); domainCtl = '0;
    accSize = 2'b10; accAddr = 32'h1234_5678; accUser = 1; accWrite = 1;
    issue(4'b0000, "R2 MMU off no translation fault");
  endtask

  task automatic t_translation;
    mmuEnable = 1'b1; accSize = 2'b10; accUser = 0; accWrite = 0;
    setMap(1'b0, 2'b00, 4'h7, 8'hFF); accAddr = 32'h0010_0000; issue(4'b0101, "R3 section");
    setMap(1'b0, 2'b11, 4'h7, 8'hFF); accAddr = 32'h0010_0400; issue(4'b0111, "R3 tiny page");
  endtask

  task automatic t_domain;
    mmuEnable = 1'b1; accSize = 2'b10; accUser = 0; accWrite = 0;
    domainCtl = 32'hFFFF_FFFF; domainCtl[11:10] = 2'b00;
    setMap(1'b1, 2'b00, 4'd5, 8'hFF); accAddr = 32'h0020_0000; issue(4'b1001, "R4 domain 5 no access section");
    domainCtl[11:10] = 2'b10;
    setMap(1'b1, 2'b10, 4'd5, 8'hFF); accAddr = 32'h0020_1000; issue(4'b1011, "R4 reserved rights page");
    setMap(1'b1, 2'b10, 4'd6, 8'hFF); issue(4'b0000, "R4 neighbour domain 6 manager");
  endtask

  task automatic t_manager;
    mmuEnable = 1'b1; accSize = 2'b10; accUser = 1; accWrite = 1;
    domainCtl = '0; domainCtl[5:4] = 2'b11;
    setMap(1'b1, 2'b01, 4'd2, 8'h00); accAddr = 32'h0030_0000; issue(4'b0000, "R5 manager ignores perm 00");
  endtask

  task automatic t_client;
    mmuEnable = 1'b1; accSize = 2'b10; accAddr = 32'h0040_0000;
    domainCtl = '0; domainCtl[19:18] = 2'b01;
    setMap(1'b1, 2'b00, 4'd9, 8'b00);
    accUser = 0; accWrite = 0; issue(4'b1101, "R6 perm 00 privileged read");
    mapPerm = 8'b01;
    accUser = 0; accWrite = 1; issue(4'b0000, "R6 perm 01 privileged write");
    accUser = 1; accWrite = 0; issue(4'b1101, "R6 perm 01 user read");
    mapPerm = 8'b10;
    accUser = 1; accWrite = 0; issue(4'b0000, "R6 perm 10 user read");
    accUser = 1; accWrite = 1; issue(4'b1101, "R6 perm 10 user write");
    accUser = 0; accWrite = 1; issue(4'b0000, "R6 perm 10 privileged write");
    mapPerm = 8'b11;
    accUser = 1; accWrite = 1; issue(4'b0000, "R6 perm 11 user write");
  endtask

  task automatic t_subpage;
    mmuEnable = 1'b1; accSize = 2'b10; accUser = 1; accWrite = 1;
    domainCtl = '0; domainCtl[3:2] = 2'b01;
    setMap(1'b1, 2'b01, 4'd1, 8'b11_00_11_11);
    accAddr = 32'h0050_8000; issue(4'b1111, "R7 large subpage 2 denied");
    accAddr = 32'h0050_4000; issue(4'b0000, "R7 large subpage 1 allowed");
    accAddr = 32'h0050_0800; issue(4'b0000, "R7 large ignores bits 11:10");
    setMap(1'b1, 2'b10, 4'd1, 8'b00_11_11_11);
    accAddr = 32'h0050_0C00; issue(4'b1111, "R7 small subpage 3 denied");
    accAddr = 32'h0050_C000; issue(4'b0000, "R7 small ignores bits 15:14");
    setMap(1'b1, 2'b00, 4'd1, 8'b00_00_00_11);
    accAddr = 32'h0050_CC00; issue(4'b0000, "R7 section uses field 0");
    setMap(1'b1, 2'b11, 4'd1, 8'b11_11_11_00);
    accAddr = 32'h0050_0000; issue(4'b1111, "R7 tiny uses field 0");
  endtask

  task automatic t_fetch;
    mmuEnable = 1'b1; accSize = 2'b10; accUser = 0; accWrite = 0; accIsFetch = 1;
    setMap(1'b0, 2'b10, 4'd4, 8'hFF); accAddr = 32'h0060_0000; issue(4'b0111, "R10 fetch translation fault");
    accSize = 2'b01; accAddr = 32'h0060_0001; issue(4'b0001, "R10 fetch misaligned");
    accIsFetch = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_alignment;
    t_mmu_off;
    t_translation;
    t_domain;
    t_manager;
    t_client;
    t_subpage;
    t_fetch;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule